// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block keeps the status reporting state of a programmable instrument. A command processor drives one-cycle event pulses that set sticky bits in an 8-bit event status register. An 8-bit enable mask reduces that register to a single summary bit. The summary bit, together with a message-available flag, forms a status byte. A second mask over the status byte produces a master summary condition, and from it a latched service request.

A numeric execution-error code register records the last command processing error. Any non-zero code it is written with raises the execution-error event bit. No mask of its own stands in front of that bit. Software-side access goes through one simple register port: write strobes load the masks and the error code. Read strobes return the register contents combinationally in the same cycle, and the registers that clear on read are cleared at the clock edge that ends the access.

Top module: `stat_report`

## Requirements
- R1: After reset the event status register reads 128 (only bit 7, power-on, set). The event enable mask, the service enable mask and the error code all read 0, and `srq` is low.
- R2: A read of the event status register (read address 0) returns its full value and clears it. An event pulse in the same cycle as that read is held in the register after the clear.
- R3: Each `evt_set` bit 0 to 6 sets the matching event status bit, and the bit stays set until the register is read. Bit 0 is operation complete, bit 2 is query sequence error and bit 3 is verify timeout. Bit 7 of `evt_set` has no effect.
- R4: A write of the error code (write address 4) with a non-zero value sets event status bit 4, and a write of 0 leaves it unchanged. Code values are 0 none, 100 numeric range, 102 empty recall store, 103 invalid in current mode and 200 access denied. A read of the code at read address 4 returns it and clears it to 0.
- R5: Status byte bit 5 (`esb`) is 1 exactly when the event status register and its enable mask share a set bit.
- R6: The event enable mask (address 1) and the service enable mask (address 3) accept any 8-bit value, and reading them back returns the value last written.
- R7: Status byte bits 7 and 3 always read 0, bit 4 follows the `mav` input, and bits 2 to 0 read 0.
- R8: `mss` is 1 when any status byte bit 0 to 5 or 7 is also set in the service enable mask. Bit 6 of that mask has no effect. A status byte query (read address 2) returns `mss` in bit 6.
- R9: `srq` sets on a rising edge of `mss` and clears when a serial poll read (read address 5) completes. A serial poll returns the status byte with `srq` in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_set | input | 8 | One-cycle event pulses, one per event status bit |
| mav | input | 1 | Message available flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 1 event mask, 3 service mask, 4 error code |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; the clear-on-read action happens at the clock edge |
| rd_addr | input | 3 | Read address 0 to 5 |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| esb | output | 1 | Event summary bit |
| mss | output | 1 | Master summary condition |
| srq | output | 1 | Service request |

## Verification
The assertions assume that every strobe lasts one clock cycle and that `evt_set` is a pulse. They also assume that read and write addresses stay within the map. The bench therefore drives each access for exactly one cycle at the falling edge, and it uses only the listed addresses. The service request checks assume that nothing else moves `mss` while a poll is in flight, so the bench sequences mask writes, event pulses and polls one at a time.

// File: rtl/stat_report.sv
module stat_report #(
  parameter int W = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_set,
  input  logic          mav,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          esb,
  output logic          mss,
  output logic          srq
);
  localparam logic [AW-1:0] A_EVT  = 3'd0;
  localparam logic [AW-1:0] A_EMSK = 3'd1;
  localparam logic [AW-1:0] A_STB  = 3'd2;
  localparam logic [AW-1:0] A_SMSK = 3'd3;
  localparam logic [AW-1:0] A_ERR  = 3'd4;
  localparam logic [AW-1:0] A_POLL = 3'd5;
  localparam logic [W-1:0]  PON    = 8'h80;
  localparam logic [W-1:0]  EXE    = 8'h10;
  localparam logic [W-1:0]  NO_RQ  = 8'hBF;

  logic [W-1:0] evt_q, emsk_q, smsk_q, err_q, stb;
  logic mss_q;

  wire evt_rd  = rd_en && rd_addr == A_EVT;
  wire err_rd  = rd_en && rd_addr == A_ERR;
  wire poll_rd = rd_en && rd_addr == A_POLL;
  wire err_wr  = wr_en && wr_addr == A_ERR;
  wire err_nz  = err_wr && wr_data != '0;

  assign esb = |(evt_q & emsk_q);
  assign stb = {1'b0, 1'b0, esb, mav, 4'b0000};
  assign mss = |(stb & smsk_q & NO_RQ);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_q  <= PON;
      emsk_q <= '0;
      smsk_q <= '0;
      err_q  <= '0;
      mss_q  <= 1'b0;
      srq    <= 1'b0;
    end else begin
      evt_q <= (evt_rd ? '0 : evt_q) | (evt_set & ~PON) | (err_nz ? EXE : '0);
      if (wr_en && wr_addr == A_EMSK) emsk_q <= wr_data;
      if (wr_en && wr_addr == A_SMSK) smsk_q <= wr_data;
      if (err_wr)      err_q <= wr_data;
      else if (err_rd) err_q <= '0;
      mss_q <= mss;
      if (mss && !mss_q) srq <= 1'b1;
      else if (poll_rd)  srq <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    if (rd_en)
      case (rd_addr)
        A_EVT:   rd_data = evt_q;
        A_EMSK:  rd_data = emsk_q;
        A_STB:   rd_data = stb | {1'b0, mss, 6'b0};
        A_SMSK:  rd_data = smsk_q;
        A_ERR:   rd_data = err_q;
        A_POLL:  rd_data = stb | {1'b0, srq, 6'b0};
        default: rd_data = '0;
      endcase
  end

  p_evt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && evt_set == '0 && !err_wr) |=> evt_q == '0);
  p_evt_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && evt_set[0]) |=> evt_q[0]);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_rd |=> (evt_q & $past(evt_q)) == $past(evt_q));
  p_err_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_nz |=> evt_q[4]);
  p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !err_wr) |=> err_q == '0);
  p_emsk_rb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_EMSK) |=> emsk_q == $past(wr_data));
  p_srq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mss && !mss_q) |=> srq);
  p_srq_poll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !(mss && !mss_q)) |=> !srq);
endmodule

// File: tb/stat_report_bench.sv
module stat_report_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;
  localparam logic [1:0] OWR = 2'd0, ORD = 2'd1, OEV = 2'd2, OMV = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] evt_set = '0, wr_data = '0;
  logic mav = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic esb, mss, srq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_report u_stat_report (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .mav(mav),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .esb(esb), .mss(mss), .srq(srq)
  );

  // {req, op, addr, data, expected}
  localparam logic [24:0] VEC [NV] = '{
    {4'd1, ORD, 3'd0, 8'h00, 8'h80},  // R1 power-on value
    {4'd2, ORD, 3'd0, 8'h00, 8'h00},  // R2 cleared by read
    {4'd1, ORD, 3'd1, 8'h00, 8'h00},  // R1
    {4'd1, ORD, 3'd3, 8'h00, 8'h00},  // R1
    {4'd1, ORD, 3'd4, 8'h00, 8'h00},  // R1
    {4'd7, ORD, 3'd2, 8'h00, 8'h00},  // R7
    {4'd3, OEV, 3'd0, 8'h01, 8'h00},
    {4'd3, ORD, 3'd0, 8'h00, 8'h01},  // R3 operation complete
    {4'd3, OEV, 3'd0, 8'h80, 8'h00},
    {4'd3, ORD, 3'd0, 8'h00, 8'h00},  // R3 bit 7 ignored
    {4'd3, OEV, 3'd0, 8'h0C, 8'h00},
    {4'd3, OEV, 3'd0, 8'h01, 8'h00},
    {4'd3, ORD, 3'd0, 8'h00, 8'h0D},  // R3 sticky
    {4'd4, OWR, 3'd4, 8'd100, 8'h00},
    {4'd4, ORD, 3'd0, 8'h00, 8'h10},  // R4 error raises bit 4
    {4'd4, ORD, 3'd4, 8'h00, 8'd100}, // R4
    {4'd4, ORD, 3'd4, 8'h00, 8'h00},  // R4 cleared on read
    {4'd4, OWR, 3'd4, 8'd0, 8'h00},
    {4'd4, ORD, 3'd0, 8'h00, 8'h00},  // R4 zero code no event
    {4'd6, OWR, 3'd1, 8'h24, 8'h00},
    {4'd6, ORD, 3'd1, 8'h00, 8'h24},  // R6
    {4'd5, OEV, 3'd0, 8'h04, 8'h00},
    {4'd5, ORD, 3'd2, 8'h00, 8'h20},  // R5 summary set
    {4'd5, ORD, 3'd0, 8'h00, 8'h04},
    {4'd5, ORD, 3'd2, 8'h00, 8'h00},  // R5 summary clear
    {4'd7, OMV, 3'd0, 8'h01, 8'h00},
    {4'd7, ORD, 3'd2, 8'h00, 8'h10},  // R7 mav at bit 4
    {4'd7, OMV, 3'd0, 8'h00, 8'h00},
    {4'd6, OWR, 3'd3, 8'hFF, 8'h00},
    {4'd6, ORD, 3'd3, 8'h00, 8'hFF},  // R6
    {4'd8, OEV, 3'd0, 8'h04, 8'h00},
    {4'd8, ORD, 3'd2, 8'h00, 8'h60},  // R8 master summary
    {4'd9, ORD, 3'd5, 8'h00, 8'h60},  // R9 poll shows request
    {4'd9, ORD, 3'd5, 8'h00, 8'h20}   // R9 request cleared by poll
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    #1 chk(req, rd_data, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ev(input logic [7:0] e);
    @(negedge clk); evt_set = e;
    @(negedge clk); evt_set = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    total++; if (srq !== 1'b0) begin bad++; $display("FAIL R1 actual=%b expected=0", srq); end
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      case (v[20:19])
        OWR: wr(v[18:16], v[15:8]);
        ORD: rd(int'(v[24:21]), v[18:16], v[7:0]);
        OEV: ev(v[15:8]);
        default: begin @(negedge clk); mav = v[8]; end
      endcase
    end
    // R8: service mask bit 6 ignored
    wr(3'd3, 8'h40);
    rd(8, 3'd2, 8'h20);
    rd(2, 3'd0, 8'h04);
    // R2: event in the same cycle as the clearing read survives
    ev(8'h01);
    @(negedge clk); rd_en = 1'b1; rd_addr = 3'd0; evt_set = 8'h02;
    #1 chk(2, rd_data, 8'h01);
    @(negedge clk); rd_en = 1'b0; evt_set = '0;
    rd(2, 3'd0, 8'h02);
    // R9: request on rising master summary only
    wr(3'd1, 8'h01);
    wr(3'd3, 8'h20);
    ev(8'h01);
    @(negedge clk);
    total++; if (srq !== 1'b1) begin bad++; $display("FAIL R9 actual=%b expected=1", srq); end
    total++; if (mss !== 1'b1) begin bad++; $display("FAIL R8 actual=%b expected=1", mss); end
    rd(9, 3'd5, 8'h60);
    total++; if (srq !== 1'b0) begin bad++; $display("FAIL R9 actual=%b expected=0", srq); end
    ev(8'h01);
    @(negedge clk);
    total++; if (srq !== 1'b0) begin bad++; $display("FAIL R9 actual=%b expected=0", srq); end
    rd(5, 3'd0, 8'h01);
    total++; if (esb !== 1'b0) begin bad++; $display("FAIL R5 actual=%b expected=0", esb); end
    ev(8'h01);
    @(negedge clk);
    total++; if (srq !== 1'b1) begin bad++; $display("FAIL R9 actual=%b expected=1", srq); end
    // R4: access denied code
    wr(3'd4, 8'd200);
    rd(4, 3'd4, 8'd200);
    // R1: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    total++; if (srq !== 1'b0) begin bad++; $display("FAIL R1 actual=%b expected=0", srq); end
    rd(1, 3'd0, 8'h80);
    rd(1, 3'd3, 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule